// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a fully associative translation cache. It maps a virtual page number to a physical frame number for the address space that is currently running. Every entry holds a page number, a frame number, permission bits and an address-space tag. A lookup compares the requested page and the current address-space tag against all entries at once. The frame and the permission bits come back combinationally in the same cycle.

When a lookup misses, the caller walks the page table elsewhere. It then presents the translation on the refill port, which is a valid/ready channel. The new entry goes into the cache on the next clock edge. The address-space tag stays in each entry, so the cache needs no flush on a context switch. Software can flush everything, or only the entries of one address space. It can also pin chosen entries, so that neither replacement nor a flush ever removes them.

Back-pressure on the refill channel: `rf_ready` is low in any cycle where a flush is requested. A refill is accepted only when `rf_valid` and `rf_ready` are both high at a rising edge. The caller must hold the refill until then. The lookup inputs have no handshake; the results are valid combinationally whenever `lk_valid` is high.

Top module: `tlb_xlat`

## Requirements
- R1: A lookup hits when a valid entry has both the same page number and an address-space tag equal to `cur_asid`. In that case `lk_hit` is 1, and `lk_pfn` and `lk_perm` show that entry's data in the same cycle.
- R2: An entry whose page number matches but whose tag differs from `cur_asid` does not hit. `lk_miss` equals `lk_valid` with no hit, and `lk_hit` and `lk_miss` are never both high.
- R3: An accepted refill is written at the rising edge on which it is accepted. A lookup of the same page and tag after that edge hits and returns the refilled frame.
- R4: A refill whose page and tag are already present overwrites that entry. It does not create a second entry, and at most one entry ever matches a lookup.
- R5: When the refill is not an overwrite, it takes the lowest-numbered invalid entry if one exists. Otherwise it evicts entries in round-robin order over the non-pinned entries. The pointer starts at entry 0 after reset and moves to the entry after each evicted one.
- R6: A pinned entry is never evicted. If every entry is pinned, the refill is dropped and `rf_drop` is 1 for the one cycle after the accepting edge.
- R7: `lk_perm` bit 0 is write permission. A lookup with `lk_write` = 1 that hits an entry whose bit 0 is 0 raises `lk_fault` in the same cycle.
- R8: `flush_all` invalidates every non-pinned entry at the next edge. Pinned entries keep hitting.
- R9: `flush_asid_en` invalidates, at the next edge, only the non-pinned entries whose tag equals `flush_asid`.
- R10: A flush takes priority over a refill. `rf_ready` is 0 while `flush_all` or `flush_asid_en` is high, so a refill offered in that cycle is not written.
- R11: `pin_en` with `pin_set` = 1 pins the valid entry matching `pin_vpn` and `pin_asid`. With `pin_set` = 0 it unpins that entry, which makes it flushable again.
- R12: After reset every entry is invalid and unpinned, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_asid | input | ASID_W | Tag of the running address space |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed |
| lk_fault | output | 1 | Write hit on a page without write permission |
| lk_pfn | output | PFN_W | Frame number of the hit entry |
| lk_perm | output | PERM_W | Permission bits of the hit entry (bit 0 = write) |
| rf_valid | input | 1 | Refill offered |
| rf_ready | output | 1 | Refill can be accepted this cycle |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill address-space tag |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | PERM_W | Refill permission bits |
| rf_drop | output | 1 | Previous accepted refill was dropped (all entries pinned) |
| flush_all | input | 1 | Invalidate all non-pinned entries |
| flush_asid_en | input | 1 | Invalidate non-pinned entries of one tag |
| flush_asid | input | ASID_W | Tag to flush |
| pin_en | input | 1 | Pin/unpin request |
| pin_set | input | 1 | 1 pins, 0 unpins |
| pin_vpn | input | VPN_W | Page number of the entry to pin/unpin |
| pin_asid | input | ASID_W | Tag of the entry to pin/unpin |

## Verification
Lookup results are combinational, so the bench drives the lookup inputs on a falling edge and reads hit, frame, permission and fault one time unit later, within the same cycle. Refill, flush and pin requests are also driven on a falling edge and take effect at the next rising edge. Their effects are therefore checked with lookups made after that edge. `rf_ready` is read during the flush cycle itself, while the flush is still requested. `rf_drop` is registered, so it is sampled at the falling edge that follows the accepting rising edge. Round-robin eviction and invalid-first placement are seen at the ports as the particular pages that stop hitting once the table is full.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W   = 2;
  localparam int PERM_WR  = 0;

  typedef enum logic [1:0] {
    VIC_SAME = 2'd0,
    VIC_FREE = 2'd1,
    VIC_RR   = 2'd2,
    VIC_NONE = 2'd3
  } victim_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_rr_pick.sv
module tlb_rr_pick #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     elig,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    int c;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!any && elig[c]) begin
        idx = IDX_W'(c);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [PERM_W-1:0] rf_perm,
  output logic              rf_drop,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              pin_en,
  input  logic              pin_set,
  input  logic [VPN_W-1:0]  pin_vpn,
  input  logic [ASID_W-1:0] pin_asid
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]      valid_q, wired_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PERM_W-1:0] perm_q [N];
  logic [IDX_W-1:0]  rr_q;

  // lookup path
  logic [N-1:0]     lk_match;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_any;

  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .match(lk_match));
  tlb_prio_enc #(.N(N)) u_lk_enc (.req(lk_match), .idx(lk_idx), .any(lk_any));

  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_pfn   = lk_any ? pfn_q[lk_idx]  : '0;
  assign lk_perm  = lk_any ? perm_q[lk_idx] : '0;
  assign lk_fault = lk_hit && lk_write && !perm_q[lk_idx][PERM_WR];

  // refill victim selection
  logic [N-1:0]     rf_match, free_vec, evict_vec;
  logic [IDX_W-1:0] same_idx, free_idx, rr_idx, vic_idx;
  logic             same_any, free_any, rr_any, rf_fire;
  victim_e          vic_sel;

  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_cam (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(rf_vpn), .key_asid(rf_asid), .match(rf_match));
  tlb_prio_enc #(.N(N)) u_same_enc (.req(rf_match), .idx(same_idx), .any(same_any));

  assign free_vec  = ~valid_q & ~wired_q;
  assign evict_vec = ~wired_q;
  tlb_prio_enc #(.N(N)) u_free_enc (.req(free_vec), .idx(free_idx), .any(free_any));
  tlb_rr_pick  #(.N(N)) u_rr (.elig(evict_vec), .ptr(rr_q), .idx(rr_idx), .any(rr_any));

  always_comb begin
    if (same_any)      begin vic_sel = VIC_SAME; vic_idx = same_idx; end
    else if (free_any) begin vic_sel = VIC_FREE; vic_idx = free_idx; end
    else if (rr_any)   begin vic_sel = VIC_RR;   vic_idx = rr_idx;   end
    else               begin vic_sel = VIC_NONE; vic_idx = '0;       end
  end

  assign rf_ready = !(flush_all || flush_asid_en);
  assign rf_fire  = rf_valid && rf_ready;

  // flush and pin vectors
  logic [N-1:0] tag_eq, kill_vec, pin_match;
  for (genvar g = 0; g < N; g++) begin : g_tag
    assign tag_eq[g] = (asid_q[g] == flush_asid);
  end
  assign kill_vec = flush_all     ? ~wired_q :
                    flush_asid_en ? (tag_eq & ~wired_q) : '0;

  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pin_cam (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(pin_vpn), .key_asid(pin_asid), .match(pin_match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      rr_q    <= '0;
      rf_drop <= 1'b0;
    end else begin
      rf_drop <= rf_fire && (vic_sel == VIC_NONE);
      valid_q <= valid_q & ~kill_vec;
      if (pin_en) wired_q <= pin_set ? (wired_q | pin_match) : (wired_q & ~pin_match);
      if (rf_fire && vic_sel != VIC_NONE) begin
        valid_q[vic_idx] <= 1'b1;
        if (vic_sel == VIC_RR)
          rr_q <= (int'(vic_idx) == N - 1) ? '0 : vic_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rf_fire && vic_sel != VIC_NONE) begin
      vpn_q[vic_idx]  <= rf_vpn;
      asid_q[vic_idx] <= rf_asid;
      pfn_q[vic_idx]  <= rf_pfn;
      perm_q[vic_idx] <= rf_perm;
    end
  end
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         lk_write,
  input logic         lk_hit,
  input logic         lk_miss,
  input logic         lk_fault,
  input logic         rf_valid,
  input logic         rf_ready,
  input logic         rf_drop,
  input logic         flush_all,
  input logic         flush_asid_en,
  input logic [N-1:0] match_vec
);
  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  assert_result_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_miss) |-> lk_valid);

  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_fault_on_write_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && lk_write));

  assert_flush_blocks_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !rf_ready);

  assert_drop_follows_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_drop |-> $past(rf_valid && rf_ready));
endmodule

bind tlb_xlat tlb_xlat_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
  .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_drop(rf_drop),
  .flush_all(flush_all), .flush_asid_en(flush_asid_en), .match_vec(lk_match));

// File: tb/tlb_xlat_test.sv
`timescale 1ns/1ps
module tlb_xlat_test;
  localparam int N = 64, VW = 8, PW = 8, AW = 4, MW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cur_asid = '0;
  logic          lk_valid = 1'b0, lk_write = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_hit, lk_miss, lk_fault;
  logic [PW-1:0] lk_pfn;
  logic [MW-1:0] lk_perm;
  logic          rf_valid = 1'b0, rf_ready;
  logic [VW-1:0] rf_vpn = '0;
  logic [AW-1:0] rf_asid = '0;
  logic [PW-1:0] rf_pfn = '0;
  logic [MW-1:0] rf_perm = '0;
  logic          rf_drop;
  logic          flush_all = 1'b0, flush_asid_en = 1'b0;
  logic [AW-1:0] flush_asid = '0;
  logic          pin_en = 1'b0, pin_set = 1'b0;
  logic [VW-1:0] pin_vpn = '0;
  logic [AW-1:0] pin_asid = '0;

  int n_chk = 0, n_err = 0;
  logic last_drop;
  bit done = 0;

  tlb_xlat #(.N(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic [PW-1:0] fr(input int v, input int a);
    return PW'((v * 7 + a * 13 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input int v, input int a, input bit wr);
    @(negedge clk);
    cur_asid = AW'(a); lk_vpn = VW'(v); lk_write = wr; lk_valid = 1'b1;
    #1;
  endtask

  task automatic exp_hit(input string req, input int v, input int a, input int pfn);
    look(v, a, 1'b0);
    chk(req, int'(lk_hit), 1);
    chk(req, int'(lk_pfn), pfn);
  endtask

  task automatic exp_miss(input string req, input int v, input int a);
    look(v, a, 1'b0);
    chk(req, int'(lk_hit), 0);
    chk(req, int'(lk_miss), 1);
  endtask

  task automatic refill(input int v, input int a, input int pfn, input int pm);
    @(negedge clk);
    rf_vpn = VW'(v); rf_asid = AW'(a); rf_pfn = PW'(pfn); rf_perm = MW'(pm); rf_valid = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0;
    last_drop = rf_drop;
  endtask

  task automatic pin(input int v, input int a, input bit set);
    @(negedge clk);
    pin_vpn = VW'(v); pin_asid = AW'(a); pin_set = set; pin_en = 1'b1;
    @(negedge clk);
    pin_en = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: empty after reset
    exp_miss("R12", 0, 0);
    exp_miss("R12", 5, 1);

    // R3 R5: fill all entries of tag 1 (free slots in order)
    for (int i = 0; i < N; i++) refill(i, 1, fr(i, 1), i % 4);
    chk("R6 no drop on normal refill", int'(last_drop), 0);
    for (int i = 0; i < N; i++) begin
      exp_hit("R1 R3", i, 1, fr(i, 1));
      chk("R1 perm", int'(lk_perm), i % 4);
    end
    // R2: same pages under other tag miss
    for (int i = 0; i < N; i++) exp_miss("R2", i, 2);

    // R7: write faults follow bit 0
    for (int i = 0; i < N; i++) begin
      look(i, 1, 1'b1);
      chk("R7", int'(lk_fault), (i % 2 == 0) ? 1 : 0);
    end

    // R4: overwrite in place, nothing evicted
    refill(5, 1, 8'hAA, 1);
    exp_hit("R4", 5, 1, 8'hAA);
    look(5, 1, 1'b1);
    chk("R4 R7 new perm", int'(lk_fault), 0);
    exp_hit("R4 no eviction", 0, 1, fr(0, 1));

    // R5: round robin from entry 0
    refill(100, 1, fr(100, 1), 1);
    exp_miss("R5 evict first", 0, 1);
    exp_hit("R5", 100, 1, fr(100, 1));
    exp_hit("R5", 1, 1, fr(1, 1));
    // R11 R6: pin page 2, eviction skips it
    pin(2, 1, 1'b1);
    refill(101, 1, fr(101, 1), 1);
    exp_miss("R5 evict second", 1, 1);
    refill(102, 1, fr(102, 1), 1);
    exp_hit("R6 R11 pinned kept", 2, 1, fr(2, 1));
    exp_miss("R6 skip to next", 3, 1);
    exp_hit("R5", 102, 1, fr(102, 1));
    refill(200, 2, fr(200, 2), 1);
    exp_miss("R5", 4, 1);

    // R9: per-tag flush
    @(negedge clk);
    flush_asid = 4'd1; flush_asid_en = 1'b1;
    @(negedge clk);
    flush_asid_en = 1'b0;
    exp_miss("R9", 6, 1);
    exp_miss("R9", 100, 1);
    exp_hit("R9 pinned", 2, 1, fr(2, 1));
    exp_hit("R9 other tag", 200, 2, fr(200, 2));

    // R5: invalid slots taken before survivors are evicted
    for (int i = 0; i < N - 2; i++) refill(10 + i, 3, fr(10 + i, 3), 1);
    exp_hit("R5 invalid first", 200, 2, fr(200, 2));
    exp_hit("R5 invalid first", 2, 1, fr(2, 1));
    for (int i = 0; i < N - 2; i++) exp_hit("R5", 10 + i, 3, fr(10 + i, 3));

    // R10 R8: flush beats a simultaneous refill
    @(negedge clk);
    flush_all = 1'b1;
    rf_vpn = 8'd150; rf_asid = 4'd3; rf_pfn = 8'h55; rf_perm = 2'd1; rf_valid = 1'b1;
    #1;
    chk("R10 ready low", int'(rf_ready), 0);
    @(negedge clk);
    flush_all = 1'b0; rf_valid = 1'b0;
    exp_miss("R10 refill not written", 150, 3);
    exp_miss("R8", 200, 2);
    exp_miss("R8", 10, 3);
    exp_hit("R8 pinned", 2, 1, fr(2, 1));

    // R11: unpin makes it flushable
    pin(2, 1, 1'b0);
    @(negedge clk);
    flush_asid = 4'd1; flush_asid_en = 1'b1;
    @(negedge clk);
    flush_asid_en = 1'b0;
    exp_miss("R11 unpinned flushed", 2, 1);

    // R6: all pinned, refill dropped
    for (int i = 0; i < N; i++) begin
      refill(i, 5, fr(i, 5), 1);
      pin(i, 5, 1'b1);
    end
    refill(250, 5, 8'h33, 1);
    chk("R6 drop flag", int'(last_drop), 1);
    exp_miss("R6 dropped", 250, 5);
    exp_hit("R6 pinned kept", 0, 5, fr(0, 5));
    exp_hit("R6 pinned kept", N - 1, 5, fr(N - 1, 5));
    @(negedge clk);
    chk("R6 drop one cycle", int'(rf_drop), 0);

    done = 1;
    summary();
  end
endmodule